// File: doc/BRIEF.md
# SD/MMC Card Clock Gate and Soft-Reset Controller

This block derives the card clock of an SD/MMC host from a fixed reference clock. A power-of-two divider selected by a 3-bit rate field sets the frequency. A gate decides whether that divided clock reaches the card. Software drives the block through a small register port. A write-only control word requests clock start, clock stop, an operation launch and a soft reset. A status word reports whether the gate is open and whether a soft reset is still running. The rate word holds the divider setting.

The gate is a four-state machine:
- `GATE_OFF`: the clock is blocked.
- `GATE_WAIT_ON`: a start is pending.
- `GATE_ON`: the clock runs.
- `GATE_WAIT_OFF`: a stop is pending.

The transitions are:
- `GATE_OFF` → `GATE_WAIT_ON` on a start request.
- `GATE_WAIT_ON` → `GATE_ON` when the divided phase is about to be low.
- `GATE_WAIT_ON` → `GATE_OFF` on a stop request.
- `GATE_ON` → `GATE_WAIT_OFF` on a stop request.
- `GATE_WAIT_OFF` → `GATE_OFF` when the divided phase is about to be low.
- `GATE_WAIT_OFF` → `GATE_ON` on a start request without a stop.
- Any state → `GATE_OFF` while a soft reset is forced.

Because the gate only opens or closes during a low phase, the card never sees a clipped high pulse.

The soft-reset sequencer has two states:
- `RST_IDLE` → `RST_HOLD` when a reset write arrives.
- `RST_HOLD` → `RST_IDLE` after a fixed hold count expires.

While it holds, the divider is cleared, the rate field reads zero and the gate is forced shut.

Top module: `sdclk_gate_ctrl`

## Requirements
- R1: Register address 0 is the control word, written as strobes: bit 0 = stop, bit 1 = start, bit 2 = launch operation, bit 3 = soft reset. Reading address 0 always returns 0.
- R2: Address 2 holds the rate n in bits [2:0] and reads it back. While the gate is open, the card clock is high for exactly 2^n and low for exactly 2^n reference cycles, a period of 2^(n+1).
- R3: Address 1 is the status word. Bit 8 is 1 while the card clock is gated on. It rises after a start write and returns to 0 after a stop has taken effect, each within one card-clock period.
- R4: The gate changes only while the card clock is low, so every high pulse on the card clock lasts exactly 2^n reference cycles.
- R5: A control write with bit 2 set gives a one-cycle `op_start` pulse in the cycle after the write. This holds even when the same write also sets start, and the clock then starts as well.
- R6: When stop and start are written in the same access, stop wins. A stopped clock stays stopped, and a running clock stops.
- R7: A soft reset holds status bit 15 (and `reset_busy`) at 1 for exactly 16 reference cycles, starting in the cycle after the write. During that time and after it, the rate reads 0 and the clock is stopped.
- R8: Register writes made while a soft reset is in progress are ignored.
- R9: A control write with the reset bit set ignores its start and launch bits: no `op_start` pulse appears and the clock stays stopped.
- R10: After the hardware reset `rst_n`, the card clock, `op_start`, both status flags and all readable registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 status, 2 rate |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address, same map |
| rd_data | output | 16 | Combinational read data |
| card_clk | output | 1 | Gated, divided card clock |
| op_start | output | 1 | One-cycle operation launch pulse |
| clk_running | output | 1 | Gate is open (status bit 8) |
| reset_busy | output | 1 | Soft reset in progress (status bit 15) |

## Verification
Several control functions can be requested in one control write, so they can land on the same cycle. A start and a stop can arrive together. A clock start can arrive with an operation launch. A soft reset can arrive with start and launch. The bench provokes each case with a single combined write, made both with the clock stopped and with it running. It judges the result from `op_start` in the following cycle, from the status flags over the next few hundred cycles, and from a monitor that measures every high and low run of the card clock against the selected rate.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
    localparam int REG_W      = 16;
    localparam int ADDR_W     = 2;
    localparam int RATE_W     = 3;

    localparam logic [ADDR_W-1:0] A_CTRL   = 2'd0;
    localparam logic [ADDR_W-1:0] A_STATUS = 2'd1;
    localparam logic [ADDR_W-1:0] A_RATE   = 2'd2;

    localparam int B_STOP   = 0;
    localparam int B_START  = 1;
    localparam int B_LAUNCH = 2;
    localparam int B_RESET  = 3;

    localparam int S_RUNNING = 8;
    localparam int S_BUSY    = 15;

    typedef enum logic [1:0] {
        GATE_OFF,
        GATE_WAIT_ON,
        GATE_ON,
        GATE_WAIT_OFF
    } gate_state_e;

    typedef enum logic {
        RST_IDLE,
        RST_HOLD
    } rst_state_e;
endpackage

// File: rtl/sdclk_divider.sv
module sdclk_divider #(
    parameter int RATE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [RATE_W-1:0] rate,
    output logic              phase_nxt
);
    localparam int CNT_W = (1 << RATE_W) - 1;

    logic [CNT_W-1:0] cnt_q, cnt_d, limit;
    logic             phase_q, phase_d, wrap;

    always_comb begin
        limit = (CNT_W'(1) << rate) - CNT_W'(1);
        wrap  = (cnt_q >= limit);
        if (clr) begin
            cnt_d   = '0;
            phase_d = 1'b0;
        end else if (wrap) begin
            cnt_d   = '0;
            phase_d = ~phase_q;
        end else begin
            cnt_d   = cnt_q + CNT_W'(1);
            phase_d = phase_q;
        end
    end

    assign phase_nxt = phase_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
        end else begin
            cnt_q   <= cnt_d;
            phase_q <= phase_d;
        end
    end

    // R7
    div_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0 && !phase_q));
endmodule

// File: rtl/sdclk_gate_fsm.sv
module sdclk_gate_fsm
    import sdclk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic force_off,
    input  logic start_req,
    input  logic stop_req,
    input  logic phase_nxt,
    output logic gate_nxt,
    output logic gate_q
);
    gate_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GATE_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (force_off) begin
            state_d = GATE_OFF;
        end else begin
            unique case (state_q)
                GATE_OFF:      if (start_req && !stop_req) state_d = GATE_WAIT_ON;
                GATE_WAIT_ON:  if (stop_req)               state_d = GATE_OFF;
                               else if (!phase_nxt)        state_d = GATE_ON;
                GATE_ON:       if (stop_req)               state_d = GATE_WAIT_OFF;
                GATE_WAIT_OFF: if (start_req && !stop_req) state_d = GATE_ON;
                               else if (!phase_nxt)        state_d = GATE_OFF;
                default:                                   state_d = GATE_OFF;
            endcase
        end
    end

    always_comb begin
        gate_nxt = (state_d == GATE_ON) || (state_d == GATE_WAIT_OFF);
        gate_q   = (state_q == GATE_ON) || (state_q == GATE_WAIT_OFF);
    end

    // R6
    stop_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && start_req) |=> !$rose(gate_q));
endmodule

// File: rtl/sdclk_reset_seq.sv
module sdclk_reset_seq
    import sdclk_pkg::*;
#(
    parameter int RST_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic busy
);
    localparam int CW = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;

    rst_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            RST_IDLE: if (trig) begin
                state_d = RST_HOLD;
                cnt_d   = CW'(RST_CYCLES - 1);
            end
            RST_HOLD: if (cnt_q == '0) state_d = RST_IDLE;
                      else             cnt_d   = cnt_q - CW'(1);
            default:  state_d = RST_IDLE;
        endcase
    end

    assign busy = (state_q == RST_HOLD);

    // R7
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && !busy) |=> busy);
endmodule

// File: rtl/sdclk_gate_ctrl.sv
module sdclk_gate_ctrl
    import sdclk_pkg::*;
#(
    parameter int RST_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    output logic              card_clk,
    output logic              op_start,
    output logic              clk_running,
    output logic              reset_busy
);
    logic              busy, wr_ctrl, wr_rate, rst_strobe, hold_off;
    logic              start_req, stop_req, phase_nxt, gate_nxt, gate_q;
    logic [RATE_W-1:0] rate_q;
    logic              card_clk_q, op_start_q;
    logic              unused_bits;

    assign unused_bits = ^{wr_data[REG_W-1:B_RESET+1]};

    always_comb begin
        wr_ctrl    = wr_en && (wr_addr == A_CTRL) && !busy;
        wr_rate    = wr_en && (wr_addr == A_RATE) && !busy;
        rst_strobe = wr_ctrl && wr_data[B_RESET];
        hold_off   = rst_strobe || busy;
        stop_req   = wr_ctrl && wr_data[B_STOP];
        start_req  = wr_ctrl && wr_data[B_START] && !wr_data[B_RESET];
    end

    sdclk_divider #(.RATE_W(RATE_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (hold_off),
        .rate      (rate_q),
        .phase_nxt (phase_nxt)
    );

    sdclk_gate_fsm u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .force_off (hold_off),
        .start_req (start_req),
        .stop_req  (stop_req),
        .phase_nxt (phase_nxt),
        .gate_nxt  (gate_nxt),
        .gate_q    (gate_q)
    );

    sdclk_reset_seq #(.RST_CYCLES(RST_CYCLES)) u_rst (
        .clk   (clk),
        .rst_n (rst_n),
        .trig  (rst_strobe),
        .busy  (busy)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rate_q     <= '0;
            card_clk_q <= 1'b0;
            op_start_q <= 1'b0;
        end else begin
            if (hold_off)     rate_q <= '0;
            else if (wr_rate) rate_q <= wr_data[RATE_W-1:0];
            card_clk_q <= phase_nxt && gate_nxt;
            op_start_q <= wr_ctrl && wr_data[B_LAUNCH] && !wr_data[B_RESET];
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            A_STATUS: begin
                rd_data[S_RUNNING] = gate_q;
                rd_data[S_BUSY]    = busy;
            end
            A_RATE:  rd_data[RATE_W-1:0] = rate_q;
            default: rd_data = '0;
        endcase
    end

    assign card_clk    = card_clk_q;
    assign op_start    = op_start_q;
    assign clk_running = gate_q;
    assign reset_busy  = busy;

    // R4
    gate_open_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_running) |-> !card_clk);
    // R4
    gate_close_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(clk_running) && !reset_busy) |-> !card_clk);
    // R7
    reset_rate_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_busy |-> (rate_q == '0 && !clk_running));
endmodule

// File: tb/test_sdclk_gate_ctrl.sv
module test_sdclk_gate_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        card_clk, op_start, clk_running, reset_busy;

    int n_tests = 0;
    int n_fail  = 0;
    int exp_half = 1;
    int hi_run = 0, lo_run = 0, rises = 0;
    bit seen_fall = 0;

    always #10 clk = ~clk;

    sdclk_gate_ctrl i_sdclk_gate_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .card_clk(card_clk), .op_start(op_start),
        .clk_running(clk_running), .reset_busy(reset_busy)
    );

    // rate, expected half period
    localparam int NV = 5;
    localparam int VEC_RATE [NV] = '{0, 1, 2, 3, 7};
    localparam int VEC_HALF [NV] = '{1, 2, 4, 8, 128};

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        rd_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    task automatic wait_run(input bit lvl, output int ok);
        ok = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (clk_running == lvl) begin ok = 1; break; end
        end
    endtask

    // card clock monitor: R2 low runs and R4 high runs
    always @(negedge clk) begin
        if (!rst_n) begin
            hi_run = 0; lo_run = 0; seen_fall = 0;
        end else if (card_clk) begin
            if (hi_run == 0) begin
                rises++;
                if (seen_fall && clk_running) check("R2 low run", lo_run, exp_half);
            end
            hi_run++; lo_run = 0;
        end else begin
            if (hi_run != 0) begin
                check("R4 high run", hi_run, exp_half);
                seen_fall = 1;
            end
            hi_run = 0; lo_run++;
            if (!clk_running) seen_fall = 0;
        end
    end

    initial begin
        #(20 * 200000);
        n_fail++; n_tests++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int v, ok, r0, cnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        rd(2'd0, v); check("R10 ctrl read", v, 0);
        rd(2'd1, v); check("R10 status read", v, 0);
        rd(2'd2, v); check("R10 rate read", v, 0);
        check("R10 card_clk", int'(card_clk), 0);
        check("R10 op_start", int'(op_start), 0);

        // table walk: R2 R3 R4
        for (int k = 0; k < NV; k++) begin
            wr(2'd2, 16'(VEC_RATE[k]));
            rd(2'd2, v); check("R2 rate readback", v, VEC_RATE[k]);
            exp_half = VEC_HALF[k];
            wr(2'd0, 16'h0002);
            rd(2'd0, v); check("R1 ctrl reads zero", v, 0);
            wait_run(1'b1, ok); check("R3 start takes effect", ok, 1);
            rd(2'd1, v); check("R3 status bit 8 set", v, 32'h100);
            repeat (8 * VEC_HALF[k] + 4) @(negedge clk);
            wr(2'd0, 16'h0001);
            wait_run(1'b0, ok); check("R3 stop takes effect", ok, 1);
            rd(2'd1, v); check("R3 status bit 8 clear", v, 0);
        end

        // R5 launch together with start
        exp_half = 1;
        wr(2'd2, 16'd0);
        wr(2'd0, 16'h0006);
        check("R5 op_start pulse", int'(op_start), 1);
        @(negedge clk);
        check("R5 op_start one cycle", int'(op_start), 0);
        wait_run(1'b1, ok); check("R5 clock started with launch", ok, 1);

        // R6 stop+start while running
        wr(2'd0, 16'h0003);
        wait_run(1'b0, ok); check("R6 running clock stops", ok, 1);
        // R6 stop+start while stopped
        r0 = rises;
        wr(2'd0, 16'h0003);
        repeat (50) @(negedge clk);
        check("R6 stopped stays stopped", int'(clk_running), 0);
        check("R6 no card clock edges", rises - r0, 0);

        // R7 soft reset duration and clearing
        wr(2'd2, 16'd5);
        wr(2'd0, 16'h0008);
        cnt = 0;
        while (reset_busy && cnt < 100) begin
            cnt++;
            @(negedge clk);
        end
        check("R7 busy duration", cnt, 16);
        rd(2'd2, v); check("R7 rate cleared", v, 0);
        rd(2'd1, v); check("R7 status after reset", v, 0);

        // R8 writes during reset ignored
        wr(2'd0, 16'h0008);
        check("R8 busy set", int'(reset_busy), 1);
        wr(2'd2, 16'd4);
        wr(2'd0, 16'h0006);
        check("R8 launch ignored", int'(op_start), 0);
        wait_run(1'b0, ok);
        while (reset_busy) @(negedge clk);
        repeat (20) @(negedge clk);
        rd(2'd2, v); check("R8 rate write ignored", v, 0);
        check("R8 start ignored", int'(clk_running), 0);

        // R9 reset with start and launch
        r0 = rises;
        wr(2'd0, 16'h000E);
        check("R9 no launch pulse", int'(op_start), 0);
        check("R9 busy", int'(reset_busy), 1);
        while (reset_busy) @(negedge clk);
        repeat (20) @(negedge clk);
        check("R9 clock stays off", int'(clk_running), 0);
        check("R9 no card edges", rises - r0, 0);

        // R10 hardware reset mid-run
        wr(2'd2, 16'd1);
        exp_half = 2;
        wr(2'd0, 16'h0002);
        wait_run(1'b1, ok);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R10 async clear running", int'(clk_running), 0);
        check("R10 async clear card_clk", int'(card_clk), 0);
        rd(2'd2, v); check("R10 async clear rate", v, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule